// File: doc/BRIEF.md
# Register Bank Slave with Request/Grant Bus and Error Responses

This block sits on a request/grant register bus and holds a small bank of control and status words. A manager raises a request with an address, a direction, byte enables, write data and a transaction tag. The slave grants the request and returns exactly one response beat one cycle after acceptance. The beat carries read data, an error flag and the tag of the request. The beat stays on the bus until the manager takes it.

Each register is a word at byte address `4*k` for `k < NREG`. Two parameter masks mark each register as readable, writable or both. Two independent parameters decide whether a response signals an error. The first covers an address that hits no register. The second covers an access in a direction the register does not allow. The current contents of all registers are driven on a flat output so that hardware can use the control values.

Top module: `regbus_slave`

## Requirements
- R1: `gnt_o` is high when no response is pending, or when the pending response is taken in the same cycle (`rready_i` high). It is low while a response waits with `rready_i` low. A request is accepted on a rising edge where `req_i` and `gnt_o` are both high. `rvalid_o` is high in the cycle after acceptance and drops after a beat completes with no new acceptance.
- R2: While `rvalid_o` is high and `rready_i` is low, `rvalid_o`, `rdata_o`, `err_o` and `rid_o` hold their values.
- R3: `rid_o` equals the `aid_i` of the request being answered. Responses come back in acceptance order.
- R4: Register `k` lives at byte address `4*k`. Bit `k` of `RD_EN` makes it readable and bit `k` of `WR_EN` makes it writable. With the default masks, registers 0 and 1 are read-write, register 2 is read-only and register 3 is write-only. A read of a readable register returns its value. `regs_o[k*DW +: DW]` shows register `k`.
- R5: A write updates byte `b` (bits `8b+7:8b`) only when `be_i[b]` is 1.
- R6: An address is unmapped when its two low bits are nonzero or when `addr_i >> 2` is at least `NREG`. When `ERR_UNMAPPED` is 1, an access to an unmapped address returns `err_o`=1. When it is 0, such an access returns `err_o`=0.
- R7: When `ERR_DIRECTION` is 1, a read of a non-readable register or a write to a non-writable register returns `err_o`=1. When it is 0, these accesses return `err_o`=0. The two error options act independently.
- R8: A write to an unmapped address or to a non-writable register changes no register, whatever the options are.
- R9: A read of an unmapped or non-readable register returns `rdata_o`=0, even when no error is flagged.
- R10: A synchronous active-high `rst` loads every register with its slice of `RST_VAL` and clears `rvalid_o`. The default value of register 2 is 0x12345678 and the default value of register 1 is 0x000000FF.
- R11: A write also produces one response beat, with `rdata_o`=0.
- R12: Outside reset, `gnt_o` and `rvalid_o` are never unknown. While `rvalid_o` is high, `rdata_o`, `err_o` and `rid_o` are never unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request valid |
| gnt_o | output | 1 | Request granted |
| addr_i | input | AW | Byte address |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | DW/8 | Byte enables |
| wdata_i | input | DW | Write data |
| aid_i | input | IDW | Request tag |
| rvalid_o | output | 1 | Response valid |
| rready_i | input | 1 | Manager takes the response |
| rdata_o | output | DW | Read data |
| err_o | output | 1 | Error flag |
| rid_o | output | IDW | Tag of the answered request |
| regs_o | output | NREG*DW | Current register contents, register k at k*DW |

## Verification
The hardest case to reach is a granted request in the same cycle that the previous response is being taken, because the manager must keep `req_i` high across the edge that retires the earlier beat. The bench holds the request with new fields and checks that the second tag follows the first. All four combinations of the error options are covered by four instances that receive the same stimulus, so each access is judged under every option setting at once. A long stall with `rready_i` low, and a reset while a response is pending, exercise the hold and clear paths.

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int IDW = 4,
  parameter int NREG = 4,
  parameter logic [NREG-1:0] RD_EN = 4'b0111,
  parameter logic [NREG-1:0] WR_EN = 4'b1011,
  parameter logic [NREG*DW-1:0] RST_VAL = {32'h0000_0000, 32'h1234_5678, 32'h0000_00FF, 32'h0000_0000},
  parameter bit ERR_UNMAPPED = 1'b1,
  parameter bit ERR_DIRECTION = 1'b1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  output logic               gnt_o,
  input  logic [AW-1:0]      addr_i,
  input  logic               we_i,
  input  logic [DW/8-1:0]    be_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [IDW-1:0]     aid_i,
  output logic               rvalid_o,
  input  logic               rready_i,
  output logic [DW-1:0]      rdata_o,
  output logic               err_o,
  output logic [IDW-1:0]     rid_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int NB = DW / 8;
  localparam int OB = $clog2(NB);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int WW = AW - OB;

  logic [DW-1:0]  regs_q [NREG];
  logic           rvalid_q, err_q;
  logic [DW-1:0]  rdata_q;
  logic [IDW-1:0] rid_q;

  logic [WW-1:0] word;
  logic [IW-1:0] idx;
  logic          hit, can_rd, can_wr, bad_dir, err_d, accept;

  assign word    = addr_i[AW-1:OB];
  assign idx     = word[IW-1:0];
  assign hit     = (addr_i[OB-1:0] == '0) && (word < WW'(NREG));
  assign can_rd  = hit && RD_EN[idx];
  assign can_wr  = hit && WR_EN[idx];
  assign bad_dir = hit && (we_i ? !WR_EN[idx] : !RD_EN[idx]);
  assign err_d   = (ERR_UNMAPPED && !hit) || (ERR_DIRECTION && bad_dir);

  assign gnt_o  = !rvalid_q || rready_i;
  assign accept = req_i && gnt_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
      rid_q    <= '0;
      for (int k = 0; k < NREG; k++) regs_q[k] <= RST_VAL[k*DW +: DW];
    end else if (accept) begin
      rvalid_q <= 1'b1;
      err_q    <= err_d;
      rid_q    <= aid_i;
      rdata_q  <= (!we_i && can_rd) ? regs_q[idx] : '0;
      if (we_i && can_wr)
        for (int b = 0; b < NB; b++)
          if (be_i[b]) regs_q[idx][8*b +: 8] <= wdata_i[8*b +: 8];
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_out
    assign regs_o[k*DW +: DW] = regs_q[k];
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign err_o    = err_q;
  assign rid_o    = rid_q;
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int DW = 32,
  parameter int IDW = 4
)(
  input logic           clk,
  input logic           rst,
  input logic           req,
  input logic           gnt,
  input logic [IDW-1:0] aid,
  input logic           rready,
  input logic           rvalid,
  input logic [DW-1:0]  rdata,
  input logic           err,
  input logic [IDW-1:0] rid
);
  assert_no_grant_when_blocked_R1: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |-> !gnt);

  assert_accept_gives_beat_R1: assert property (@(posedge clk) disable iff (rst)
    (req && gnt) |=> rvalid);

  assert_hold_while_stalled_R2: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(err) && $stable(rid)));

  assert_tag_echo_R3: assert property (@(posedge clk) disable iff (rst)
    (req && gnt) |=> (rid == $past(aid)));

  assert_error_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
    (rvalid && err) |-> (rdata == '0));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !rvalid);

  assert_known_R12: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({gnt, rvalid}) && (!rvalid || !$isunknown({rdata, err, rid})));
endmodule

bind regbus_slave regbus_slave_chk #(.DW(DW), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .req(req_i), .gnt(gnt_o), .aid(aid_i),
  .rready(rready_i), .rvalid(rvalid_o), .rdata(rdata_o), .err(err_o), .rid(rid_o)
);

// File: tb/test_regbus_slave.sv
module test_regbus_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10ns clk = ~clk;

  logic        req = 1'b0, we = 1'b0, rready = 1'b1;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0, aid = '0;
  logic [31:0] wdata = '0;

  logic         gnt [4], rvalid [4], err [4];
  logic [31:0]  rdata [4];
  logic [3:0]   rid [4];
  logic [127:0] regs [4];

  localparam logic [127:0] RSTV = {32'h0000_0000, 32'h1234_5678, 32'h0000_00FF, 32'h0000_0000};
  localparam logic [3:0] RDM = 4'b0111, WRM = 4'b1011;

  for (genvar g = 0; g < 4; g++) begin : g_dut
    regbus_slave #(.ERR_UNMAPPED(g % 2 == 0), .ERR_DIRECTION(g < 2)) i_regbus_slave (
      .clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt[g]), .addr_i(addr), .we_i(we),
      .be_i(be), .wdata_i(wdata), .aid_i(aid), .rvalid_o(rvalid[g]), .rready_i(rready),
      .rdata_o(rdata[g]), .err_o(err[g]), .rid_o(rid[g]), .regs_o(regs[g]));
  end

  int n_run = 0, n_fail = 0;
  logic [127:0] model = RSTV;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk(regs[0] == model, tag, regs[0], model);
    chk(regs[3] == model, tag, regs[3], model);
  endtask

  task automatic txn(string tag, logic [7:0] a, bit w, logic [3:0] b, logic [31:0] d,
                     logic [3:0] id, bit u, bit dir, logic [31:0] exp_rd, int stall);
    logic [1:0] k = a[3:2];
    @(negedge clk);
    req = 1'b1; addr = a; we = w; be = b; wdata = d; aid = id; rready = (stall == 0);
    #1;
    while (!gnt[0]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; #1;
    chk(rvalid[0] == 1'b1, {tag, " R1 beat"}, rvalid[0], 1);
    for (int s = 0; s < stall; s++) begin
      chk(gnt[0] == 1'b0, {tag, " R1 blocked"}, gnt[0], 0);
      @(negedge clk); #1;
      chk(rvalid[0] && rid[0] == id && rdata[0] == exp_rd, {tag, " R2 hold"}, {rvalid[0], rid[0], rdata[0]}, {1'b1, id, exp_rd});
    end
    rready = 1'b1; #1;
    chk(gnt[0] == 1'b1, {tag, " R1 regrant"}, gnt[0], 1);
    for (int g = 0; g < 4; g++) begin
      bit e = (u && (g % 2 == 0)) || (dir && g < 2);
      chk(err[g] == e, {tag, " R6 R7 err"}, err[g], e);
    end
    chk(rid[0] == id, {tag, " R3 rid"}, rid[0], id);
    chk(rdata[0] == exp_rd, {tag, " R9 R11 rdata"}, rdata[0], exp_rd);
    if (!u && w && WRM[k])
      for (int i = 0; i < 4; i++) if (b[i]) model[k*32 + i*8 +: 8] = d[i*8 +: 8];
    @(posedge clk);
    @(negedge clk); #1;
    chk(rvalid[0] == 1'b0, {tag, " R1 retire"}, rvalid[0], 0);
    chk_regs({tag, " R8 regs"});
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(rvalid[0] == 1'b0 && gnt[0] == 1'b1, "R10 idle", {rvalid[0], gnt[0]}, 2'b01);
    chk_regs("R10 reset values");
  endtask

  task automatic t_readwrite();
    txn("R4 wr0", 8'h00, 1, 4'hF, 32'hDEAD_BEEF, 4'h3, 0, 0, 32'h0, 0);
    txn("R4 rd0", 8'h00, 0, 4'h0, 32'h0, 4'h5, 0, 0, 32'hDEAD_BEEF, 0);
  endtask

  task automatic t_bytes();
    txn("R5 wr1", 8'h04, 1, 4'b0101, 32'h1122_3344, 4'h7, 0, 0, 32'h0, 0);
    txn("R5 rd1", 8'h04, 0, 4'h0, 32'h0, 4'h8, 0, 0, 32'h0022_0044, 0);
  endtask

  task automatic t_readonly();
    txn("R4 rd2", 8'h08, 0, 4'h0, 32'h0, 4'h9, 0, 0, 32'h1234_5678, 0);
    txn("R7 wr2", 8'h08, 1, 4'hF, 32'hFFFF_FFFF, 4'hA, 0, 1, 32'h0, 0);
  endtask

  task automatic t_writeonly();
    txn("R4 wr3", 8'h0C, 1, 4'hF, 32'hCAFE_F00D, 4'hB, 0, 0, 32'h0, 0);
    txn("R9 rd3", 8'h0C, 0, 4'h0, 32'h0, 4'hC, 0, 1, 32'h0, 0);
  endtask

  task automatic t_unmapped();
    txn("R6 rd10", 8'h10, 0, 4'h0, 32'h0, 4'h1, 1, 0, 32'h0, 0);
    txn("R8 wr14", 8'h14, 1, 4'hF, 32'h5555_5555, 4'h2, 1, 0, 32'h0, 0);
    txn("R6 rd02", 8'h02, 0, 4'h0, 32'h0, 4'h4, 1, 0, 32'h0, 0);
    txn("R8 wr05", 8'h05, 1, 4'hF, 32'h7777_7777, 4'h6, 1, 0, 32'h0, 0);
  endtask

  task automatic t_stall();
    txn("R2 stall", 8'h00, 0, 4'h0, 32'h0, 4'hD, 0, 0, 32'hDEAD_BEEF, 3);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h00; aid = 4'h1; rready = 1'b1; #1;
    while (!gnt[0]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    addr = 8'h08; aid = 4'h2; #1;
    chk(gnt[0] == 1'b1, "R1 grant while retiring", gnt[0], 1);
    chk(rid[0] == 4'h1 && rdata[0] == 32'hDEAD_BEEF, "R3 first beat", {rid[0], rdata[0]}, {4'h1, 32'hDEAD_BEEF});
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; #1;
    chk(rvalid[0] && rid[0] == 4'h2 && rdata[0] == 32'h1234_5678, "R3 second beat in order",
        {rvalid[0], rid[0], rdata[0]}, {1'b1, 4'h2, 32'h1234_5678});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_pending();
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h04; aid = 4'hE; rready = 1'b0; #1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; rready = 1'b1; #1;
    model = RSTV;
    chk(rvalid[0] == 1'b0, "R10 pending beat dropped", rvalid[0], 0);
    chk_regs("R10 regs reloaded");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readwrite();
    t_bytes();
    t_readonly();
    t_writeonly();
    t_unmapped();
    t_stall();
    t_back_to_back();
    t_reset_pending();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule